// File: doc/BRIEF.md
# Function-Unit Dependency Matrix

This block keeps the ordering hazards among a small pool of function units (eight by default) as a square grid of single-bit cells, with two planes. When an operation is issued into an idle unit, that unit's row records which busy units it must wait for. The read plane holds read-after-write waits, on units that produce its source operands. The write plane holds write-after-write waits, on units that target the same destination. From these rows the block drives a read grant per unit, which lets the unit fetch operands and start executing. It also drives a write grant per unit, which lets the unit commit its buffered result. Load and store units take part as ordinary rows and columns.

Two controls support precise exceptions and speculation. A per-unit write hold keeps the write grant low while an exception or a branch outcome is still unresolved, and it leaves the read grant alone, so execution can start early. A per-unit kill frees a mis-speculated unit and erases every cell in its row and its column. When a unit commits, its column is wiped in the same cycle, which releases every unit that waited on it. An in-order issue flag makes the new unit wait on every busy unit in the write plane, so results commit in program order.

Top module: `fu_dep_matrix`

## Requirements
- R1: After a synchronous active-low reset, no unit is busy, all read and write grants are low, and all cells are clear.
- R2: An issue is accepted (`issue_accept` high) only when the addressed unit is idle. An accepted issue makes that unit busy from the next cycle. An issue into a busy unit is refused and changes no busy flag and no grant.
- R3: At an accepted issue, each bit j of `issue_rd_dep` sets a read-plane cell toward unit j only if unit j is busy, is not the issued unit itself, and is not being released that cycle. `rd_go[i]` is high exactly when unit i is busy and its read-plane row is empty.
- R4: `issue_wr_dep` sets write-plane cells under the same conditions as in R3. `wr_go[i]` is high exactly when `rd_go[i]` is high, the write-plane row of unit i is empty, and `wr_hold[i]` is low.
- R5: `wr_hold[i]` high forces `wr_go[i]` low and leaves `rd_go[i]` unchanged.
- R6: `wr_done[i]` takes effect only in a cycle where `wr_go[i]` is high. When it does, unit i becomes idle in the next cycle, and column i is cleared in every row. Without the grant, `wr_done[i]` is ignored.
- R7: `kill[i]` makes unit i idle in the next cycle and clears both its row and its column in both planes. This includes a cycle in which unit i is being issued, where the kill wins.
- R8: When a column is released (commit or kill) in the same cycle that an issue requests a dependency on it, the release wins and the new row does not record that cell.
- R9: With `issue_in_order` high, the issued unit gets a write-plane cell toward every busy unit that is not being released, whatever `issue_wr_dep` says. A chain of such issues therefore grants commit only to the oldest busy unit.
- R10: `wr_go[i]` never asserts while any set cell in row i refers to a busy unit, and a set cell only ever refers to a busy unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Issue request this cycle |
| issue_fu | input | IDX_W | Index of the unit to issue into |
| issue_rd_dep | input | NUM_FU | Units producing the new operation's sources |
| issue_wr_dep | input | NUM_FU | Units writing the new operation's destination |
| issue_in_order | input | 1 | Make the new unit wait to commit behind all busy units |
| issue_accept | output | 1 | Issue taken (target unit idle) |
| wr_hold | input | NUM_FU | Per-unit commit hold while an exception or branch is unresolved |
| wr_done | input | NUM_FU | Per-unit result written (honoured only with its write grant) |
| kill | input | NUM_FU | Per-unit cancel of a mis-speculated operation |
| busy | output | NUM_FU | Per-unit busy flag |
| rd_go | output | NUM_FU | Per-unit read grant |
| wr_go | output | NUM_FU | Per-unit write grant |

## Verification
On every cycle the assertions check the structural invariants of the grid. A cell may only point at a busy unit. An idle unit's row stays empty. A released column is empty one cycle later. A held unit, or one still waiting on a busy unit, never gets a write grant, and kills and honoured commits free their unit. The priorities need the bench's directed scenarios to be seen: a release winning over a same-cycle dependency, a commit request without its grant being ignored, an in-order chain draining oldest-first, and a refused issue leaving the state untouched. A long random run then compares every grant and busy flag against a behavioural model on each clock.

// File: rtl/fdm_pkg.sv
// Package: shared definitions for the function-unit dependency matrix.
// Assumes nothing beyond being compiled before the modules that import it.
package fdm_pkg;

    // Default size of the unit pool.
    parameter int unsigned FDM_DEF_UNITS = 8;

    // Which hazard plane a row of cells belongs to.
    typedef enum logic [0:0] {
        DEP_READ  = 1'b0,   // read-after-write waits, gate the read grant
        DEP_WRITE = 1'b1    // write-after-write waits, gate the write grant
    } dep_kind_e;

endpackage

// File: rtl/fdm_dep_row.sv
// Module: one row of single-bit dependency cells for one unit in one plane.
// On load it captures the requested dependencies that point at live units.
// In the write plane an in-order flag captures every live unit instead.
// Columns being released are wiped every cycle; the row is wiped on release of its own unit.
// Assumes the caller has already removed the unit's own column and released columns from `live`.
module fdm_dep_row
    import fdm_pkg::*;
#(
    parameter int unsigned NUM_FU = FDM_DEF_UNITS,
    parameter dep_kind_e   KIND   = DEP_READ
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              force_all,
    input  logic [NUM_FU-1:0] req,
    input  logic [NUM_FU-1:0] live,
    input  logic [NUM_FU-1:0] clr_col,
    input  logic              clr_row,
    output logic [NUM_FU-1:0] cells
);

    logic [NUM_FU-1:0] set_vec;

    // Select the captured pattern: all live units for in-order writes, else the request.
    always_comb begin
        if (KIND == DEP_WRITE && force_all)
            set_vec = live;
        else
            set_vec = req & live;
    end

    // Cell storage: row release first, then load, else column wipe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cells <= '0;
        else if (clr_row)
            cells <= '0;
        else if (load)
            cells <= set_vec;
        else
            cells <= cells & ~clr_col;
    end

    AST_COL_WIPED: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_col) |=> ((cells & $past(clr_col)) == '0)); // R6

endmodule

// File: rtl/fdm_grant.sv
// Module: per-unit grant logic.
// A busy unit with an empty read-plane row may read.
// A reading unit with an empty write-plane row and no hold may commit.
// Assumes the row summaries are single bits per unit (OR of the row).
module fdm_grant #(
    parameter int unsigned NUM_FU = 8
) (
    input  logic [NUM_FU-1:0] busy,
    input  logic [NUM_FU-1:0] raw_any,
    input  logic [NUM_FU-1:0] waw_any,
    input  logic [NUM_FU-1:0] hold,
    output logic [NUM_FU-1:0] rd_go,
    output logic [NUM_FU-1:0] wr_go
);

    // Form both grants from busy state, row summaries and hold.
    always_comb begin
        rd_go = busy & ~raw_any;
        wr_go = rd_go & ~waw_any & ~hold;
    end

endmodule

// File: rtl/fu_dep_matrix.sv
// Module: function-unit dependency matrix (top).
// Holds a busy flag per unit and two NUM_FU x NUM_FU planes of dependency cells.
// It issues into idle units, grants read and commit, and releases units on commit or kill.
// Assumes NUM_FU >= 2 and issue_fu < NUM_FU. Outputs are combinational from state and
// the per-cycle controls (wr_hold, issue_valid/issue_fu).
module fu_dep_matrix
    import fdm_pkg::*;
#(
    parameter  int unsigned NUM_FU = FDM_DEF_UNITS,
    localparam int unsigned IDX_W  = $clog2(NUM_FU)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [IDX_W-1:0]  issue_fu,
    input  logic [NUM_FU-1:0] issue_rd_dep,
    input  logic [NUM_FU-1:0] issue_wr_dep,
    input  logic              issue_in_order,
    output logic              issue_accept,
    input  logic [NUM_FU-1:0] wr_hold,
    input  logic [NUM_FU-1:0] wr_done,
    input  logic [NUM_FU-1:0] kill,
    output logic [NUM_FU-1:0] busy,
    output logic [NUM_FU-1:0] rd_go,
    output logic [NUM_FU-1:0] wr_go
);

    logic [NUM_FU-1:0] busy_q;
    logic [NUM_FU-1:0] release_v;
    logic [NUM_FU-1:0] live_v;
    logic [NUM_FU-1:0] load_v;
    logic [NUM_FU-1:0] raw_any;
    logic [NUM_FU-1:0] waw_any;
    logic [NUM_FU-1:0] raw_cells [NUM_FU];
    logic [NUM_FU-1:0] waw_cells [NUM_FU];

    // Release set (honoured commits plus kills) and the units still live after it.
    always_comb begin
        release_v = (wr_done & wr_go) | kill;
        live_v    = busy_q & ~release_v;
    end

    // Accept only into an idle unit.
    always_comb begin
        issue_accept = issue_valid && !busy_q[issue_fu];
    end

    // Busy flags: release beats issue for the same unit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= '0;
        else
            busy_q <= (busy_q | load_v) & ~release_v;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FU; gi++) begin : g_unit
            localparam logic [NUM_FU-1:0] SELF = NUM_FU'(1) << gi;
            logic [NUM_FU-1:0] live_row;

            // Decode the issue index and exclude the unit's own column.
            always_comb begin
                load_v[gi] = issue_accept && (issue_fu == IDX_W'(gi));
                live_row   = live_v & ~SELF;
            end

            fdm_dep_row #(.NUM_FU(NUM_FU), .KIND(DEP_READ)) u_raw_row (
                .clk       (clk),
                .rst_n     (rst_n),
                .load      (load_v[gi]),
                .force_all (1'b0),
                .req       (issue_rd_dep),
                .live      (live_row),
                .clr_col   (release_v),
                .clr_row   (release_v[gi]),
                .cells     (raw_cells[gi])
            );

            fdm_dep_row #(.NUM_FU(NUM_FU), .KIND(DEP_WRITE)) u_waw_row (
                .clk       (clk),
                .rst_n     (rst_n),
                .load      (load_v[gi]),
                .force_all (issue_in_order),
                .req       (issue_wr_dep),
                .live      (live_row),
                .clr_col   (release_v),
                .clr_row   (release_v[gi]),
                .cells     (waw_cells[gi])
            );

            // Summarise each row for the grant logic.
            always_comb begin
                raw_any[gi] = |raw_cells[gi];
                waw_any[gi] = |waw_cells[gi];
            end

            AST_CELLS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
                ((raw_cells[gi] | waw_cells[gi]) & ~busy_q) == '0); // R10
            AST_IDLE_ROW_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
                !busy_q[gi] |-> ((raw_cells[gi] | waw_cells[gi]) == '0)); // R7
            AST_NO_WR_GO_ON_DEP: assert property (@(posedge clk) disable iff (!rst_n)
                wr_go[gi] |-> (((raw_cells[gi] | waw_cells[gi]) & busy_q) == '0)); // R10
            AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
                wr_hold[gi] |-> !wr_go[gi]); // R5
            AST_WR_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
                wr_go[gi] |-> rd_go[gi]); // R4
            AST_KILL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
                kill[gi] |=> !busy_q[gi]); // R7
            AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_done[gi] && wr_go[gi]) |=> !busy_q[gi]); // R6
        end
    endgenerate

    fdm_grant #(.NUM_FU(NUM_FU)) u_grant (
        .busy    (busy_q),
        .raw_any (raw_any),
        .waw_any (waw_any),
        .hold    (wr_hold),
        .rd_go   (rd_go),
        .wr_go   (wr_go)
    );

    // Drive the busy port from state.
    always_comb begin
        busy = busy_q;
    end

    AST_ISSUE_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_accept && !kill[issue_fu]) |=> busy_q[$past(issue_fu)]); // R2

endmodule

// File: tb/tb_fu_dep_matrix.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared against the matrix on every clock.
module tb_fu_dep_matrix;
    localparam int N = 8;
    localparam int W = $clog2(N);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         issue_valid = 1'b0;
    logic [W-1:0] issue_fu = '0;
    logic [N-1:0] issue_rd_dep = '0, issue_wr_dep = '0;
    logic         issue_in_order = 1'b0;
    logic         issue_accept;
    logic [N-1:0] wr_hold = '0, wr_done = '0, kill = '0;
    logic [N-1:0] busy, rd_go, wr_go;

    fu_dep_matrix #(.NUM_FU(N)) dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_fu(issue_fu),
        .issue_rd_dep(issue_rd_dep), .issue_wr_dep(issue_wr_dep),
        .issue_in_order(issue_in_order), .issue_accept(issue_accept),
        .wr_hold(wr_hold), .wr_done(wr_done), .kill(kill),
        .busy(busy), .rd_go(rd_go), .wr_go(wr_go)
    );

    always #4 clk = ~clk;   // 125 MHz

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    string cur_req = "R1";

    // Model state: busy flags and the lists of units each unit waits on.
    bit mbusy [N];
    bit mrd [N][N];
    bit mwr [N][N];

    function automatic bit waits_on(input int i, input bit plane_wr);
        for (int j = 0; j < N; j++)
            if (plane_wr ? mwr[i][j] : mrd[i][j]) return 1;
        return 0;
    endfunction

    task automatic cmp(input string what, input logic [N-1:0] act, input logic [N-1:0] exp_v);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, what, act, exp_v, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            mbusy[i] = 0;
            for (int j = 0; j < N; j++) begin mrd[i][j] = 0; mwr[i][j] = 0; end
        end
    endtask

    // One cycle: drive, compare after settling, advance the model at the edge.
    task automatic step(input bit v, input int fu, input logic [N-1:0] rdm, input logic [N-1:0] wrm,
                        input bit ord, input logic [N-1:0] hold, input logic [N-1:0] done,
                        input logic [N-1:0] kl);
        logic [N-1:0] e_busy, e_rd, e_wr;
        bit e_acc;
        bit rel [N];
        bit nrd [N][N];
        bit nwr [N][N];
        bit nb [N];
        issue_valid = v; issue_fu = W'(fu); issue_rd_dep = rdm; issue_wr_dep = wrm;
        issue_in_order = ord; wr_hold = hold; wr_done = done; kill = kl;
        #2;
        for (int i = 0; i < N; i++) begin
            e_busy[i] = mbusy[i];
            e_rd[i]   = mbusy[i] && !waits_on(i, 0);
            e_wr[i]   = e_rd[i] && !waits_on(i, 1) && !hold[i];
        end
        e_acc = v && !mbusy[fu];
        cmp("busy (R2)", busy, e_busy);
        cmp("rd_go (R3)", rd_go, e_rd);
        cmp("wr_go (R4/R10)", wr_go, e_wr);
        cmp("issue_accept (R2)", N'(issue_accept), N'(e_acc));
        for (int i = 0; i < N; i++) rel[i] = (done[i] && e_wr[i]) || kl[i];
        for (int i = 0; i < N; i++) begin
            nb[i] = mbusy[i];
            for (int j = 0; j < N; j++) begin
                nrd[i][j] = mrd[i][j] && !rel[j];
                nwr[i][j] = mwr[i][j] && !rel[j];
            end
            if (e_acc && i == fu) begin
                nb[i] = 1;
                for (int j = 0; j < N; j++) begin
                    bit ok;
                    ok = mbusy[j] && !rel[j] && (j != i);
                    nrd[i][j] = ok && rdm[j];
                    nwr[i][j] = ok && (wrm[j] || ord);
                end
            end
            if (rel[i]) begin
                nb[i] = 0;
                for (int j = 0; j < N; j++) begin nrd[i][j] = 0; nwr[i][j] = 0; end
            end
        end
        @(posedge clk);
        if (rst_n) begin
            for (int i = 0; i < N; i++) begin
                mbusy[i] = nb[i];
                for (int j = 0; j < N; j++) begin mrd[i][j] = nrd[i][j]; mwr[i][j] = nwr[i][j]; end
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(); step(0, 0, '0, '0, 0, '0, '0, '0); endtask
    task automatic issue(input int fu, input logic [N-1:0] rdm, input logic [N-1:0] wrm, input bit ord);
        step(1, fu, rdm, wrm, ord, '0, '0, '0);
    endtask
    task automatic flush(); step(0, 0, '0, '0, 0, '0, '0, '1); endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        model_reset();
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cur_req = "R1"; idle();
        // R2: issue into idle unit, then refused re-issue
        cur_req = "R2"; issue(0, '0, '0, 0); issue(0, 8'h02, 8'h02, 1); idle();
        // R3: read dependency on busy unit 0; dependency on idle unit 3 ignored
        cur_req = "R3"; issue(1, 8'h01, '0, 0); issue(2, 8'h08, '0, 0); idle();
        // R5: hold unit 0, read grant remains
        cur_req = "R5"; step(0, 0, '0, '0, 0, 8'h01, '0, '0); step(0, 0, '0, '0, 0, 8'h05, 8'h05, '0);
        // R6: done without grant ignored (unit 1 blocked), then honoured commit of unit 0
        cur_req = "R6"; step(0, 0, '0, '0, 0, '0, 8'h02, '0); step(0, 0, '0, '0, 0, '0, 8'h01, '0); idle();
        // R4: write-after-write on unit 4
        cur_req = "R4"; issue(4, '0, '0, 0); issue(5, '0, 8'h10, 0); idle();
        // R7: kill unit 4 frees unit 5; kill during issue wins
        cur_req = "R7"; step(0, 0, '0, '0, 0, '0, '0, 8'h10); idle();
        step(1, 3, '0, '0, 0, '0, '0, 8'h08); idle();
        // R8: dependency requested on a column released the same cycle
        cur_req = "R8"; step(1, 6, 8'h20, 8'h20, 0, '0, 8'h20, '0); idle();
        flush(); idle();
        // R9: in-order chain commits oldest first
        cur_req = "R9"; issue(0, '0, '0, 1); issue(1, '0, '0, 1); issue(2, '0, '0, 1); idle();
        step(0, 0, '0, '0, 0, '0, 8'h07, '0); step(0, 0, '0, '0, 0, '0, 8'h06, '0);
        step(0, 0, '0, '0, 0, '0, 8'h04, '0); idle();
        // R10: random mix compared every clock
        cur_req = "R10";
        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0] h, d, kl;
            h  = ($urandom_range(3) == 0) ? N'($urandom) : '0;
            d  = N'($urandom);
            kl = ($urandom_range(15) == 0) ? (N'(1) << $urandom_range(N-1)) : '0;
            step($urandom_range(1), $urandom_range(N-1), N'($urandom) & N'($urandom),
                 N'($urandom) & N'($urandom), $urandom_range(7) == 0, h, d, kl);
        end
        // R1 again: reset clears everything mid-traffic
        cur_req = "R1"; issue(7, '0, '0, 0);
        rst_n = 1'b0; @(posedge clk); @(negedge clk); model_reset(); rst_n = 1'b1; idle();
        summary();
    end
endmodule